// File: doc/BRIEF.md
# Multidrop Nine-Bit Address Filter

This block sits on the receive path of a serial port, between the character deserializer and the receive queue. It is used on a shared multidrop line. The port runs with a ninth bit in the slot where a parity bit would normally go. When that bit is set, the character is an address. When it is clear, the character is data. Parity checking is not done in this mode.

Each address is compared with a programmed station address under a programmable mask. A matching address selects the station. A non-matching address deselects it. Data characters are written into the queue only while the station is selected. A match also latches an interrupt. When the mode is switched off, every character goes to the queue unchanged.

On the transmit side, the block adds the ninth bit at the moment a character is launched, because the transmit queue does not store that bit. By default the bit is clear. A per-character force input sets it to mark an address.

Top module: `md9_filter`

## Requirements
- R1: With `cfg_enable` low, every character presented with `rx_valid` appears on `fifo_wr`/`fifo_data` one clock later, whatever its ninth bit, and `match_pulse` stays low.
- R2: With `cfg_enable` high, a character with `rx_ninth`=1 is an address. It matches when (rx_data & mask) == (address & mask). A match raises `match_pulse` for exactly the one clock after the character.
- R3: After reset the address register holds 0 and the mask register holds all ones, so only the exact address matches. A write through `reg_we_addr` or `reg_we_mask` loads `reg_wdata` and takes effect for characters presented from the next clock on.
- R4: After reset the station is deselected, so data characters (`rx_ninth`=0) are dropped until a matching address has arrived.
- R5: With `cfg_enable` high, an address character is never written to the queue, whether it matches or not.
- R6: After a matching address, each following data character is written one clock later, with `fifo_data` equal to `rx_data`.
- R7: A non-matching address deselects the station. Data characters after it are dropped until the next matching address.
- R8: `irq_raw` is set by a match and stays set until `irq_clr` is pulsed. A match in the same clock as a clear wins over the clear.
- R9: `irq_out` equals `irq_raw` AND `irq_en`.
- R10: One clock after `tx_launch`, `tx_valid` is high, `tx_char` holds `tx_data`, and `tx_ninth` equals `tx_force_addr` if `cfg_enable` is high and 0 otherwise.
- R11: Lowering `cfg_enable` deselects the station. After the mode is enabled again, data is dropped until a matching address arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Nine-bit multidrop mode on |
| reg_we_addr | input | 1 | Load station address from reg_wdata |
| reg_we_mask | input | 1 | Load address mask from reg_wdata |
| reg_wdata | input | CHAR_W | Register write data |
| rx_valid | input | 1 | Received character present |
| rx_ninth | input | 1 | Ninth bit of received character |
| rx_data | input | CHAR_W | Received character |
| fifo_wr | output | 1 | Write strobe to receive queue |
| fifo_data | output | CHAR_W | Character to receive queue |
| match_pulse | output | 1 | One-clock address match indication |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clear latched interrupt |
| irq_raw | output | 1 | Latched match status |
| irq_out | output | 1 | Enabled interrupt |
| tx_launch | input | 1 | Character leaves transmit queue |
| tx_data | input | CHAR_W | Character being launched |
| tx_force_addr | input | 1 | Mark this character as an address |
| tx_valid | output | 1 | Launched character valid |
| tx_char | output | CHAR_W | Launched character |
| tx_ninth | output | 1 | Ninth bit for launched character |

## Verification
The hardest behavior to show at the ports is the masked compare. It has to be right for every byte value, and a partial mask gives a match set that differs from the exact-address case. The bench loads several address/mask pairs, including all ones, a partial mask and an all-zero mask. For each pair it sweeps all 256 address values, each followed by one data character. It computes in arithmetic whether each address should match and whether the data after it should be stored. This drives the selection state through every select/deselect transition between neighbouring addresses.

// File: rtl/md9_pkg.sv
package md9_pkg;
   typedef enum logic {
      SEL_IDLE   = 1'b0,
      SEL_ACTIVE = 1'b1
   } md9_sel_e;
endpackage

// File: rtl/md9_cfg_regs.sv
module md9_cfg_regs #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_addr,
   input  logic              we_mask,
   input  logic [CHAR_W-1:0] wdata,
   output logic [CHAR_W-1:0] addr_q,
   output logic [CHAR_W-1:0] mask_q
);
   localparam logic [CHAR_W-1:0] MASK_RST = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mask_q <= MASK_RST;
      end else begin
         if (we_addr) addr_q <= wdata;
         if (we_mask) mask_q <= wdata;
      end
   end
endmodule

// File: rtl/md9_addr_match.sv
module md9_addr_match #(
   parameter int CHAR_W = 8
) (
   input  logic [CHAR_W-1:0] rx_data,
   input  logic [CHAR_W-1:0] addr,
   input  logic [CHAR_W-1:0] mask,
   output logic              hit
);
   logic [CHAR_W-1:0] diff;

   for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
      assign diff[i] = mask[i] & (rx_data[i] ^ addr[i]);
   end

   assign hit = ~|diff;
endmodule

// File: rtl/md9_sel_ctrl.sv
module md9_sel_ctrl
   import md9_pkg::*;
#(
   parameter int CHAR_W  = 8,
   parameter bit FWD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx_valid,
   input  logic              rx_ninth,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              hit,
   output logic              match_evt,
   output logic              fifo_wr,
   output logic [CHAR_W-1:0] fifo_data,
   output logic              match_pulse
);
   md9_sel_e sel_q;
   logic     wr_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sel_q <= SEL_IDLE;
      else if (!en)                  sel_q <= SEL_IDLE;
      else if (rx_valid && rx_ninth) sel_q <= hit ? SEL_ACTIVE : SEL_IDLE;
   end

   assign wr_c      = rx_valid & (~en | (~rx_ninth & (sel_q == SEL_ACTIVE)));
   assign match_evt = rx_valid & en & rx_ninth & hit;

   if (FWD_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fifo_wr     <= 1'b0;
            fifo_data   <= '0;
            match_pulse <= 1'b0;
         end else begin
            fifo_wr     <= wr_c;
            match_pulse <= match_evt;
            if (rx_valid) fifo_data <= rx_data;
         end
      end

      // R1
      pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!en && rx_valid) |=> (fifo_wr && !match_pulse));
      // R5
      addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en && rx_valid && rx_ninth) |=> !fifo_wr);
      // R7
      desel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (en && rx_valid && !rx_ninth && sel_q == SEL_IDLE) |=> !fifo_wr);
   end else begin : g_comb
      assign fifo_wr     = wr_c;
      assign fifo_data   = rx_data;
      assign match_pulse = match_evt;
   end
endmodule

// File: rtl/md9_irq.sv
module md9_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic en,
   output logic raw,
   output logic out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   raw <= 1'b0;
      else if (set) raw <= 1'b1;
      else if (clr) raw <= 1'b0;
   end

   assign out = raw & en;

   // R8
   raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> raw);
   // R8
   raw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !raw);
endmodule

// File: rtl/md9_tx_nine.sv
module md9_tx_nine #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              launch,
   input  logic [CHAR_W-1:0] data_in,
   input  logic              force_addr,
   output logic              valid_o,
   output logic [CHAR_W-1:0] char_o,
   output logic              ninth_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         char_o  <= '0;
         ninth_o <= 1'b0;
      end else begin
         valid_o <= launch;
         if (launch) begin
            char_o  <= data_in;
            ninth_o <= en & force_addr;
         end
      end
   end

   // R10
   tx_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !en) |=> (valid_o && !ninth_o));
endmodule

// File: rtl/md9_filter.sv
module md9_filter #(
   parameter int CHAR_W  = 8,
   parameter bit FWD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              reg_we_addr,
   input  logic              reg_we_mask,
   input  logic [CHAR_W-1:0] reg_wdata,
   input  logic              rx_valid,
   input  logic              rx_ninth,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              fifo_wr,
   output logic [CHAR_W-1:0] fifo_data,
   output logic              match_pulse,
   input  logic              irq_en,
   input  logic              irq_clr,
   output logic              irq_raw,
   output logic              irq_out,
   input  logic              tx_launch,
   input  logic [CHAR_W-1:0] tx_data,
   input  logic              tx_force_addr,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_char,
   output logic              tx_ninth
);
   if (CHAR_W < 1 || CHAR_W > 32) begin : g_bad_width
      $error("md9_filter: CHAR_W out of range");
   end

   logic [CHAR_W-1:0] addr_q, mask_q;
   logic              hit, match_evt;

   md9_cfg_regs #(.CHAR_W(CHAR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_addr(reg_we_addr), .we_mask(reg_we_mask),
      .wdata(reg_wdata), .addr_q(addr_q), .mask_q(mask_q)
   );

   md9_addr_match #(.CHAR_W(CHAR_W)) u_match (
      .rx_data(rx_data), .addr(addr_q), .mask(mask_q), .hit(hit)
   );

   md9_sel_ctrl #(.CHAR_W(CHAR_W), .FWD_REG(FWD_REG)) u_sel (
      .clk(clk), .rst_n(rst_n), .en(cfg_enable), .rx_valid(rx_valid),
      .rx_ninth(rx_ninth), .rx_data(rx_data), .hit(hit), .match_evt(match_evt),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .match_pulse(match_pulse)
   );

   md9_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set(match_evt), .clr(irq_clr), .en(irq_en),
      .raw(irq_raw), .out(irq_out)
   );

   md9_tx_nine #(.CHAR_W(CHAR_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(cfg_enable), .launch(tx_launch),
      .data_in(tx_data), .force_addr(tx_force_addr), .valid_o(tx_valid),
      .char_o(tx_char), .ninth_o(tx_ninth)
   );
endmodule

// File: tb/md9_filter_tb.sv
module md9_filter_tb;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_enable = 1'b0, reg_we_addr = 1'b0, reg_we_mask = 1'b0;
   logic [W-1:0] reg_wdata = '0;
   logic rx_valid = 1'b0, rx_ninth = 1'b0;
   logic [W-1:0] rx_data = '0;
   logic fifo_wr, match_pulse, irq_raw, irq_out, tx_valid, tx_ninth;
   logic [W-1:0] fifo_data, tx_char;
   logic irq_en = 1'b0, irq_clr = 1'b0;
   logic tx_launch = 1'b0, tx_force_addr = 1'b0;
   logic [W-1:0] tx_data = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   md9_filter #(.CHAR_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
      .reg_we_addr(reg_we_addr), .reg_we_mask(reg_we_mask), .reg_wdata(reg_wdata),
      .rx_valid(rx_valid), .rx_ninth(rx_ninth), .rx_data(rx_data),
      .fifo_wr(fifo_wr), .fifo_data(fifo_data), .match_pulse(match_pulse),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq_raw(irq_raw), .irq_out(irq_out),
      .tx_launch(tx_launch), .tx_data(tx_data), .tx_force_addr(tx_force_addr),
      .tx_valid(tx_valid), .tx_char(tx_char), .tx_ninth(tx_ninth)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input bit is_mask, input logic [W-1:0] v);
      reg_wdata = v;
      if (is_mask) reg_we_mask = 1'b1; else reg_we_addr = 1'b1;
      @(negedge clk);
      reg_we_addr = 1'b0;
      reg_we_mask = 1'b0;
   endtask

   task automatic send(input logic nine, input logic [W-1:0] d);
      rx_valid = 1'b1;
      rx_ninth = nine;
      rx_data  = d;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic sweep(input logic [W-1:0] a, input logic [W-1:0] m);
      wr_reg(1'b0, a);
      wr_reg(1'b1, m);
      for (int b = 0; b < 256; b++) begin
         bit exp_hit;
         exp_hit = ((b[W-1:0] & m) == (a & m));
         send(1'b1, b[W-1:0]);
         chk("R2 match", match_pulse, exp_hit);
         chk("R5 addr not stored", fifo_wr, 0);
         send(1'b0, ~b[W-1:0]);
         chk(exp_hit ? "R6 data stored" : "R7 data dropped", fifo_wr, exp_hit);
         if (exp_hit) chk("R6 data value", fifo_data, ~b[W-1:0] & 8'hFF);
         chk("R2 pulse single", match_pulse, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset fifo_wr", fifo_wr, 0);
      chk("R8 reset irq_raw", irq_raw, 0);
      chk("R10 reset tx_valid", tx_valid, 0);

      // R1 pass-through while disabled
      send(1'b1, 8'h3C);
      chk("R1 addr passes", fifo_wr, 1);
      chk("R1 data value", fifo_data, 8'h3C);
      chk("R1 no pulse", match_pulse, 0);
      send(1'b0, 8'hC3);
      chk("R1 data passes", fifo_wr, 1);
      chk("R1 data value", fifo_data, 8'hC3);

      cfg_enable = 1'b1;
      // R4 deselected after reset
      send(1'b0, 8'h11);
      chk("R4 data dropped", fifo_wr, 0);
      // R3 reset mask all ones, address zero
      send(1'b1, 8'h01);
      chk("R3 exact mask rejects 01", match_pulse, 0);
      send(1'b1, 8'h00);
      chk("R3 reset address 00 matches", match_pulse, 1);
      chk("R5 matching addr not stored", fifo_wr, 0);
      chk("R8 irq set", irq_raw, 1);
      chk("R9 irq gated off", irq_out, 0);
      irq_en = 1'b1;
      #1 chk("R9 irq enabled", irq_out, 1);
      send(1'b0, 8'h77);
      chk("R6 data after match", fifo_wr, 1);
      chk("R6 data value", fifo_data, 8'h77);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk("R8 irq cleared", irq_raw, 0);
      chk("R9 irq_out follows", irq_out, 0);
      // R8 set wins over clear
      irq_clr = 1'b1;
      send(1'b1, 8'h00);
      irq_clr = 1'b0;
      chk("R8 set beats clear", irq_raw, 1);
      // R7 deselect
      send(1'b1, 8'h05);
      chk("R7 no pulse", match_pulse, 0);
      send(1'b0, 8'h66);
      chk("R7 dropped after miss", fifo_wr, 0);
      // R11 disable clears selection
      send(1'b1, 8'h00);
      cfg_enable = 1'b0;
      @(negedge clk);
      cfg_enable = 1'b1;
      send(1'b0, 8'h55);
      chk("R11 dropped after re-enable", fifo_wr, 0);

      // R3 register writes; R2 masked sweeps
      sweep(8'h5A, 8'hFF);
      sweep(8'h5A, 8'hF0);
      sweep(8'hA5, 8'h0F);
      sweep(8'h81, 8'h00);

      // R10 transmit ninth bit
      tx_launch = 1'b1; tx_data = 8'h9E; tx_force_addr = 1'b1;
      @(negedge clk);
      chk("R10 valid", tx_valid, 1);
      chk("R10 char", tx_char, 8'h9E);
      chk("R10 forced addr", tx_ninth, 1);
      tx_data = 8'h12; tx_force_addr = 1'b0;
      @(negedge clk);
      chk("R10 data clear", tx_ninth, 0);
      chk("R10 char", tx_char, 8'h12);
      cfg_enable = 1'b0; tx_force_addr = 1'b1;
      @(negedge clk);
      chk("R10 disabled no ninth", tx_ninth, 0);
      tx_launch = 1'b0;
      @(negedge clk);
      chk("R10 valid drops", tx_valid, 0);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule